// File: doc/BRIEF.md
# Multi-Thread Fetch Arbiter

This block decides, every clock, which one of several hardware threads may start an instruction fetch. For each thread it looks at whether the thread is running or waiting on outstanding counters, whether its line buffer still has room, whether fetch is being held off for it, and whether it already has a fetch in flight. A thread that passes all of these is latched as a candidate. Among the candidates one is chosen round-robin, and the choice leaves the block as a registered one-hot grant with a valid strobe and the thread number. The downstream line-buffer reservation logic consumes that grant.

The block also keeps the per-thread "fetch outstanding" state. A grant marks the thread as outstanding, and the return of its response clears the mark. A flush raised against a thread whose fetch is still in flight arms a discard flag, so that the late response is swallowed instead of being written into the buffer. A stall input from the request port holds back all grants without losing any candidates.

Top module: `fetch_arb_top`

## Requirements
- R1: While `rst` is high at a clock edge, every output is cleared: `grant_valid`, `grant_vec`, `grant_tid`, `pending`, `queued`, `fill_valid` and `fill_tid` all read zero after that edge.
- R2: A thread is taken as a new candidate when (`thr_run` or `thr_wait`) and `buf_free` are high, `stop_fetch` is low, and it is neither pending nor queued. A waiting thread counts the same as a running one.
- R3: A thread that is neither running nor waiting, has no buffer space, or has `stop_fetch` high is neither queued nor granted.
- R4: Once queued, a thread stays queued until it is granted or flushed, even if its run, space or stop conditions change meanwhile.
- R5: At most one grant is issued per cycle. When `grant_valid` is high, `grant_vec` has exactly bit `grant_tid` set. With no candidate, `grant_valid` is low and `grant_vec` is zero.
- R6: On the edge that issues a grant, the granted thread's `pending` bit is set and its `queued` bit is cleared. A pending thread is not taken as a candidate again.
- R7: While `req_stall` is high, no grant is issued on the following edge, and queued threads keep their `queued` bits.
- R8: Selection is round-robin. The search starts at the thread after the last one granted and wraps around. After reset the search starts at thread 0.
- R9: A response (`resp_valid` with `resp_tid`) for a pending thread clears its `pending` bit. If no discard is armed for that thread, `fill_valid` is high for one cycle after the edge and `fill_tid` equals `resp_tid`.
- R10: A `flush` bit clears that thread's `queued` bit. If the thread is pending, the flush also arms a discard. The next response for that thread then gives no `fill_valid`, clears `pending`, and disarms the discard, so the following fetch of that thread fills normally.
- R11: A response for a thread that is not pending is ignored: there is no fill and `pending` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| thr_run | input | N | Thread is running |
| thr_wait | input | N | Thread is waiting on outstanding counters |
| buf_free | input | N | Thread's line buffer has a free line |
| stop_fetch | input | N | Hold fetch off for the thread |
| flush | input | N | Restart the thread: drop queued state, discard an in-flight response |
| req_stall | input | 1 | Downstream request port cannot accept a grant |
| resp_valid | input | 1 | A fetch response returns this cycle |
| resp_tid | input | TW | Thread the response belongs to |
| grant_valid | output | 1 | A grant was issued |
| grant_vec | output | N | One-hot granted thread |
| grant_tid | output | TW | Index of the granted thread (zero when no grant) |
| pending | output | N | Per-thread fetch outstanding |
| queued | output | N | Per-thread latched candidate |
| fill_valid | output | 1 | Response data is to be written into the buffer |
| fill_tid | output | TW | Thread whose response is being filled |

## Verification
The assertions assume that a response only comes back for a thread that has a fetch outstanding, at most one per cycle, with `resp_tid` below N. They also assume `flush` is never raised for a thread in the same cycle as that thread's own response. The stimulus returns every response only after the matching grant has been observed. It never overlaps a flush with a response for the same thread. It sends one stray response on purpose, to a thread that is known not to be pending, so that R11 is exercised without breaking the outstanding-fetch bookkeeping.

// File: rtl/fa_pkg.sv
package fa_pkg;
  // Outcome of a returning fetch response
  typedef enum logic [1:0] {
    RSP_IDLE    = 2'd0,
    RSP_KEEP    = 2'd1,
    RSP_DISCARD = 2'd2,
    RSP_STRAY   = 2'd3
  } rsp_kind_e;
endpackage

// File: rtl/fa_cand_track.sv
module fa_cand_track #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] run,
  input  logic [N-1:0] waitc,
  input  logic [N-1:0] buf_free,
  input  logic [N-1:0] stop,
  input  logic [N-1:0] flush,
  input  logic [N-1:0] pend,
  input  logic [N-1:0] grant_oh,
  output logic [N-1:0] cand,
  output logic [N-1:0] queued
);
  logic [N-1:0] base;
  logic [N-1:0] fresh;
  logic [N-1:0] q_q;

  for (genvar i = 0; i < N; i++) begin : g_thr
    always_comb begin
      base[i]  = (run[i] | waitc[i]) & buf_free[i] & ~stop[i];
      fresh[i] = base[i] & ~q_q[i] & ~pend[i];
    end
  end

  // latched candidates are not re-evaluated; a flush removes them
  assign cand = (q_q | fresh) & ~flush;

  always_ff @(posedge clk) begin
    if (rst) q_q <= '0;
    else     q_q <= cand & ~grant_oh;
  end

  assign queued = q_q;

  assert_no_queue_while_pending_R6: assert property (@(posedge clk) disable iff (rst)
    (q_q & pend) == '0);

  assert_ineligible_not_queued_R3: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (q_q & $past(~q_q & ~base)) == '0);
endmodule

// File: rtl/fa_rr_pick.sv
module fa_rr_pick #(
  parameter int N  = 8,
  parameter int TW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  cand,
  input  logic          advance,
  output logic          any,
  output logic [N-1:0]  pick_oh,
  output logic [TW-1:0] pick_idx
);
  logic [TW-1:0] last_q;
  logic [N-1:0]  upper;
  logic [N-1:0]  sel;

  for (genvar i = 0; i < N; i++) begin : g_mask
    assign upper[i] = cand[i] & (TW'(i) > last_q);
  end

  assign sel = (|upper) ? upper : cand;
  assign any = |cand;

  always_comb begin
    pick_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (sel[i]) pick_idx = TW'(i);
    end
  end

  assign pick_oh = any ? (N'(1) << pick_idx) : '0;

  always_ff @(posedge clk) begin
    if (rst)          last_q <= TW'(N - 1);
    else if (advance) last_q <= pick_idx;
  end

  assert_pick_onehot_R5: assert property (@(posedge clk) disable iff (rst)
    any |-> $onehot(pick_oh));

  assert_pick_from_cand_R5: assert property (@(posedge clk) disable iff (rst)
    (pick_oh & ~cand) == '0);
endmodule

// File: rtl/fa_thread_state.sv
module fa_thread_state
  import fa_pkg::*;
#(
  parameter int N  = 8,
  parameter int TW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  grant_oh,
  input  logic [N-1:0]  flush,
  input  logic          resp_valid,
  input  logic [TW-1:0] resp_tid,
  output logic [N-1:0]  pend,
  output logic          fill_valid,
  output logic [TW-1:0] fill_tid
);
  logic [N-1:0] pend_q;
  logic [N-1:0] drop_q;
  logic [N-1:0] hit;
  logic [N-1:0] hit_pend;
  rsp_kind_e    kind;

  for (genvar i = 0; i < N; i++) begin : g_hit
    assign hit[i] = resp_valid && (resp_tid == TW'(i));
  end

  assign hit_pend = hit & pend_q;

  always_comb begin
    if (!resp_valid)            kind = RSP_IDLE;
    else if (!pend_q[resp_tid]) kind = RSP_STRAY;
    else if (drop_q[resp_tid])  kind = RSP_DISCARD;
    else                        kind = RSP_KEEP;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q     <= '0;
      drop_q     <= '0;
      fill_valid <= 1'b0;
      fill_tid   <= '0;
    end else begin
      pend_q     <= (pend_q & ~hit_pend) | grant_oh;
      drop_q     <= (drop_q | (flush & pend_q)) & ~hit_pend;
      fill_valid <= (kind == RSP_KEEP);
      if (kind == RSP_KEEP) fill_tid <= resp_tid;
    end
  end

  assign pend = pend_q;

  assert_grant_sets_pending_R6: assert property (@(posedge clk) disable iff (rst)
    (grant_oh != '0) |=> (pend_q & $past(grant_oh)) == $past(grant_oh));

  assert_drop_only_when_pending_R10: assert property (@(posedge clk) disable iff (rst)
    (drop_q & ~pend_q) == '0);

  assert_stray_no_change_R11: assert property (@(posedge clk) disable iff (rst)
    (kind == RSP_STRAY && grant_oh == '0 && flush == '0) |=> !fill_valid && $stable(pend_q));
endmodule

// File: rtl/fetch_arb_top.sv
module fetch_arb_top #(
  parameter int N  = 8,
  parameter int TW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  thr_run,
  input  logic [N-1:0]  thr_wait,
  input  logic [N-1:0]  buf_free,
  input  logic [N-1:0]  stop_fetch,
  input  logic [N-1:0]  flush,
  input  logic          req_stall,
  input  logic          resp_valid,
  input  logic [TW-1:0] resp_tid,
  output logic          grant_valid,
  output logic [N-1:0]  grant_vec,
  output logic [TW-1:0] grant_tid,
  output logic [N-1:0]  pending,
  output logic [N-1:0]  queued,
  output logic          fill_valid,
  output logic [TW-1:0] fill_tid
);
  logic [N-1:0]  cand;
  logic [N-1:0]  pick_oh;
  logic [N-1:0]  grant_oh;
  logic [TW-1:0] pick_idx;
  logic          any;
  logic          advance;

  assign advance  = any & ~req_stall;
  assign grant_oh = advance ? pick_oh : '0;

  fa_cand_track #(.N(N)) u_cand (
    .clk      (clk),
    .rst      (rst),
    .run      (thr_run),
    .waitc    (thr_wait),
    .buf_free (buf_free),
    .stop     (stop_fetch),
    .flush    (flush),
    .pend     (pending),
    .grant_oh (grant_oh),
    .cand     (cand),
    .queued   (queued)
  );

  fa_rr_pick #(.N(N), .TW(TW)) u_pick (
    .clk      (clk),
    .rst      (rst),
    .cand     (cand),
    .advance  (advance),
    .any      (any),
    .pick_oh  (pick_oh),
    .pick_idx (pick_idx)
  );

  fa_thread_state #(.N(N), .TW(TW)) u_state (
    .clk        (clk),
    .rst        (rst),
    .grant_oh   (grant_oh),
    .flush      (flush),
    .resp_valid (resp_valid),
    .resp_tid   (resp_tid),
    .pend       (pending),
    .fill_valid (fill_valid),
    .fill_tid   (fill_tid)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      grant_valid <= 1'b0;
      grant_vec   <= '0;
      grant_tid   <= '0;
    end else begin
      grant_valid <= advance;
      grant_vec   <= grant_oh;
      grant_tid   <= advance ? pick_idx : '0;
    end
  end

  assert_stall_blocks_grant_R7: assert property (@(posedge clk) disable iff (rst)
    req_stall |=> !grant_valid);

  assert_grant_vec_matches_R5: assert property (@(posedge clk) disable iff (rst)
    grant_valid |-> grant_vec == (N'(1) << grant_tid));

  assert_no_grant_zero_vec_R5: assert property (@(posedge clk) disable iff (rst)
    !grant_valid |-> grant_vec == '0);

  assert_fill_follows_resp_R9: assert property (@(posedge clk) disable iff (rst)
    fill_valid |-> $past(resp_valid) && fill_tid == $past(resp_tid));
endmodule

// File: tb/test_fetch_arb_top.sv
module test_fetch_arb_top;
  localparam int N  = 4;
  localparam int TW = 2;

  logic          clk = 1'b0;
  logic          rst;
  logic [N-1:0]  thr_run, thr_wait, buf_free, stop_fetch, flush;
  logic          req_stall, resp_valid;
  logic [TW-1:0] resp_tid;
  logic          grant_valid, fill_valid;
  logic [N-1:0]  grant_vec, pending, queued;
  logic [TW-1:0] grant_tid, fill_tid;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  fetch_arb_top #(.N(N), .TW(TW)) i_fetch_arb_top (
    .clk(clk), .rst(rst), .thr_run(thr_run), .thr_wait(thr_wait),
    .buf_free(buf_free), .stop_fetch(stop_fetch), .flush(flush),
    .req_stall(req_stall), .resp_valid(resp_valid), .resp_tid(resp_tid),
    .grant_valid(grant_valid), .grant_vec(grant_vec), .grant_tid(grant_tid),
    .pending(pending), .queued(queued), .fill_valid(fill_valid), .fill_tid(fill_tid)
  );

  // {run,wait,free,stop,stall,rv,rtid | gv,gtid,pend,fv,ftid}
  localparam int NV = 11;
  localparam logic [29:0] VEC [NV] = '{
    30'b1111_0000_1111_0000_0_0_00_1_00_0001_0_00, // R2 all new, thread 0 first (R8)
    30'b1111_0000_1111_0000_0_0_00_1_01_0011_0_00, // R8 next in turn
    30'b1111_0000_1111_0000_1_0_00_0_00_0011_0_00, // R7 stall
    30'b1111_0000_1111_1111_0_0_00_1_10_0111_0_00, // R4 queued despite stop
    30'b1111_0000_1111_0000_0_1_00_1_11_1110_1_00, // R9 fill 0, R6 grant 3
    30'b1111_0000_1111_0000_0_0_00_1_00_1111_0_00, // R8 wrap to 0
    30'b1111_0000_1111_0000_0_1_01_0_00_1101_1_01, // R6 pending blocks requeue
    30'b0000_0010_1111_0000_0_0_00_1_01_1111_0_00, // R2 waiting thread
    30'b0000_0000_1111_0000_0_1_10_0_00_1011_1_10, // R9 fill 2
    30'b0100_0000_1011_0000_0_0_00_0_00_1011_0_00, // R3 no space
    30'b0100_0000_1111_0000_0_0_00_1_10_1111_0_00  // R2 space back
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    thr_run = '0; thr_wait = '0; buf_free = '1; stop_fetch = '0;
    flush = '0; req_stall = 1'b0; resp_valid = 1'b0; resp_tid = '0;
  endtask

  task automatic do_reset();
    idle_inputs();
    rst = 1'b1;
    step(); step();
    rst = 1'b0;
  endtask

  task automatic chk_grant(input string req, input bit gv, input int tid);
    chk(grant_valid == gv, req, "grant_valid", grant_valid, gv);
    if (gv) begin
      chk(grant_tid == TW'(tid), req, "grant_tid", grant_tid, tid);
      chk(grant_vec == N'(1 << tid), req, "grant_vec", grant_vec, 1 << tid);
    end else begin
      chk(grant_vec == '0, req, "grant_vec idle", grant_vec, 0);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual 0 expected 1 (run completed)");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    idle_inputs();
    rst = 1'b1;
    thr_run = '1;
    resp_valid = 1'b1;
    step(); step();
    // R1: reset state even with active inputs
    chk({grant_valid, grant_vec, grant_tid, pending, queued, fill_valid, fill_tid} == '0,
        "R1", "outputs in reset", int'(pending), 0);
    rst = 1'b0;
    idle_inputs();

    // table walk
    for (int k = 0; k < NV; k++) begin
      logic [29:0] v;
      v = VEC[k];
      thr_run = v[29:26]; thr_wait = v[25:22]; buf_free = v[21:18]; stop_fetch = v[17:14];
      req_stall = v[13]; resp_valid = v[12]; resp_tid = v[11:10];
      step();
      chk_grant($sformatf("R5 row%0d", k), v[9], int'(v[8:7]));
      chk(pending == v[6:3], $sformatf("R6 row%0d", k), "pending", pending, v[6:3]);
      chk(fill_valid == v[2], $sformatf("R9 row%0d", k), "fill_valid", fill_valid, v[2]);
      if (v[2]) chk(fill_tid == v[1:0], $sformatf("R9 row%0d", k), "fill_tid", fill_tid, v[1:0]);
    end

    // R8: round-robin across a sparse set
    do_reset();
    thr_run = 4'b1010;
    step(); chk_grant("R8 first", 1'b1, 1);
    step(); chk_grant("R8 second", 1'b1, 3);
    thr_run = '0;
    resp_valid = 1'b1; resp_tid = 2'd1; step();
    resp_tid = 2'd3; step();
    resp_valid = 1'b0;
    thr_run = 4'b1001;
    step(); chk_grant("R8 wrap", 1'b1, 0);
    step(); chk_grant("R8 after wrap", 1'b1, 3);

    // R7 + R10: queued survives stall, flush removes it
    do_reset();
    req_stall = 1'b1; thr_run = 4'b0010;
    step();
    chk_grant("R7 stalled", 1'b0, 0);
    chk(queued == 4'b0010, "R7", "queued during stall", queued, 2);
    thr_run = '0; flush = 4'b0010;
    step();
    chk(queued == 4'b0000, "R10", "queued after flush", queued, 0);
    flush = '0; req_stall = 1'b0;
    step();
    chk_grant("R10 flushed not granted", 1'b0, 0);

    // R10: discard armed by flush on in-flight fetch
    do_reset();
    thr_run = 4'b0001;
    step(); chk_grant("R10 grant", 1'b1, 0);
    flush = 4'b0001;
    step();
    flush = '0;
    resp_valid = 1'b1; resp_tid = 2'd0;
    step();
    resp_valid = 1'b0;
    chk(fill_valid == 1'b0, "R10", "discarded fill", fill_valid, 0);
    chk(pending[0] == 1'b0, "R10", "pending after discard", pending[0], 0);
    step(); chk_grant("R10 refetch", 1'b1, 0);
    thr_run = '0;
    resp_valid = 1'b1; resp_tid = 2'd0;
    step();
    resp_valid = 1'b0;
    chk(fill_valid == 1'b1 && fill_tid == 2'd0, "R10", "fill after disarm", fill_valid, 1);

    // R11: stray response
    do_reset();
    thr_run = 4'b0001;
    step();
    thr_run = '0;
    resp_valid = 1'b1; resp_tid = 2'd2;
    step();
    resp_valid = 1'b0;
    chk(fill_valid == 1'b0, "R11", "stray fill", fill_valid, 0);
    chk(pending == 4'b0001, "R11", "pending unchanged", pending, 1);

    // R3: stop_fetch and idle thread are never granted
    do_reset();
    thr_run = 4'b0100; stop_fetch = 4'b0100;
    step(); step();
    chk_grant("R3 stopped", 1'b0, 0);
    chk(queued == '0, "R3", "queued while stopped", queued, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule